// File: doc/BRIEF.md
# Key-Locked Watchdog Timer

A watchdog timer with a small register port. A 31-bit counter advances once per pulse of a slow timebase enable (`tick_i`). It runs either unconditionally or only while the core reports itself awake. The counter is shifted right by a 4-bit scale, and the low 16 bits of the result are compared against a 16-bit compare register. When the scaled value reaches the compare value, a sticky pending flag is raised. The pending flag drives the interrupt output and, if enabled, a reset request. A match can also clear the counter, which makes the watchdog a periodic timer.

Every write to a protected register only takes effect if it directly follows a write of the unlock key. The counter can only be restarted by writing the feed word, and that write must itself be unlocked. Firmware services the dog with two writes: the key, then the feed word. Any stray write closes the unlock again.

Top module: `keylock_wdog`

## Requirements
- R1: After synchronous reset, the config register (offset 0x00), the compare register (0x20), the raw count (0x08), the key status (0x1C, bit 0 = unlocked) and both outputs all read 0.
- R2: The counter increments by exactly one for each cycle with `tick_i` high, while config bit 12 (always run) is set, or while bit 13 (run while awake) is set and `core_awake_i` is high. The counter holds when neither enable condition holds.
- R3: A write of 0x0051F15E to offset 0x1C unlocks the block, and bit 0 of a read of 0x1C then returns 1. Any later write, to any offset, relocks the block, unless that write is itself the key.
- R4: Writes to the config, compare and feed registers while locked are ignored.
- R5: An unlocked write of 0x0D09F00D to offset 0x18 clears the counter. An unlocked feed write of any other value leaves the counter unchanged and relocks the block.
- R6: Offset 0x08 returns the raw counter. Offset 0x10 returns counter bits (scale+15):scale, where scale is config bits 3:0.
- R7: While either enable bit is set and the scaled count is greater than or equal to the compare value, the pending flag (config bit 28) is set one clock later. `irq_o` equals the pending flag.
- R8: With config bit 9 set, the counter is cleared on the clock after a compare match.
- R9: `rst_req_o` is high exactly while the pending flag and config bit 8 are both set.
- R10: The pending flag stays set until an unlocked config write with bit 28 = 0 lands in a cycle with no match. A match in the same cycle keeps it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tick_i | input | 1 | Timebase enable pulse |
| core_awake_i | input | 1 | High while the core is awake |
| irq_o | output | 1 | Pending flag |
| rst_req_o | output | 1 | Reset request |

## Verification
The hardest state to reach from the ports is a clear of the pending flag that is attempted while the compare match still holds. In that case the match must win, and the flag may only drop once a second unlocked write lands after the enables are gone. The stimulus parks the counter exactly on the compare value with a known number of ticks. It then issues two clearing config writes in a row and checks `irq_o` after each one. Randomly sized tick bursts under random scales check the scaled-count window against an independent shift of the tick total.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
    localparam int unsigned ADDR_W  = 6;
    localparam int unsigned DATA_W  = 32;
    localparam int unsigned CNT_W   = 31;
    localparam int unsigned CMP_W   = 16;
    localparam int unsigned SCALE_W = 4;

    localparam logic [ADDR_W-1:0] OFS_CFG  = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_RAW  = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_SCL  = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_FEED = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_KEY  = 6'h1C;
    localparam logic [ADDR_W-1:0] OFS_CMP  = 6'h20;

    localparam logic [DATA_W-1:0] KEY_WORD  = 32'h0051_F15E;
    localparam logic [DATA_W-1:0] FEED_WORD = 32'h0D09_F00D;

    localparam int unsigned BIT_RSTEN  = 8;
    localparam int unsigned BIT_ZERO   = 9;
    localparam int unsigned BIT_ALWAYS = 12;
    localparam int unsigned BIT_AWAKE  = 13;
    localparam int unsigned BIT_PEND   = 28;

    typedef struct packed {
        logic [SCALE_W-1:0] scale;
        logic               rst_en;
        logic               zero_cmp;
        logic               en_always;
        logic               en_awake;
    } cfg_t;

    function automatic cfg_t unpack_cfg(logic [DATA_W-1:0] w);
        cfg_t c;
        c.scale     = w[SCALE_W-1:0];
        c.rst_en    = w[BIT_RSTEN];
        c.zero_cmp  = w[BIT_ZERO];
        c.en_always = w[BIT_ALWAYS];
        c.en_awake  = w[BIT_AWAKE];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] pack_cfg(cfg_t c, logic pend);
        logic [DATA_W-1:0] w;
        w                 = '0;
        w[SCALE_W-1:0]    = c.scale;
        w[BIT_RSTEN]      = c.rst_en;
        w[BIT_ZERO]       = c.zero_cmp;
        w[BIT_ALWAYS]     = c.en_always;
        w[BIT_AWAKE]      = c.en_awake;
        w[BIT_PEND]       = pend;
        return w;
    endfunction

    function automatic logic [CMP_W-1:0] scale_count(logic [CNT_W-1:0] cnt,
                                                     logic [SCALE_W-1:0] s);
        logic [CNT_W-1:0] shifted;
        shifted = cnt >> s;
        return shifted[CMP_W-1:0];
    endfunction
endpackage

// File: rtl/kwd_lock.sv
module kwd_lock
    import kwd_pkg::*;
#(
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    output logic          unlocked_o
);
    logic unlocked_q;

    always_ff @(posedge clk) begin
        if (rst)
            unlocked_q <= 1'b0;
        else if (wr)
            unlocked_q <= (addr == AW'(OFS_KEY)) && (data == DW'(KEY_WORD));
    end

    assign unlocked_o = unlocked_q;

    AST_UNLOCK_FROM_KEY: assert property (@(posedge clk) disable iff (rst)
        $rose(unlocked_q) |-> $past(wr && addr == AW'(OFS_KEY)))
        else $error("unlock without key write"); // R3

    AST_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
        (unlocked_q && wr && addr != AW'(OFS_KEY)) |=> !unlocked_q)
        else $error("unlock survived a write"); // R3
endmodule

// File: rtl/kwd_cfgregs.sv
module kwd_cfgregs
    import kwd_pkg::*;
#(
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned DW = DATA_W,
    parameter int unsigned CW = CMP_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    input  logic          unlocked,
    input  logic          match,
    output cfg_t          cfg_o,
    output logic [CW-1:0] cmp_o,
    output logic          pend_o,
    output logic          feed_clr_o
);
    logic          prot_wr;
    cfg_t          cfg_q;
    logic [CW-1:0] cmp_q;
    logic          pend_q;

    assign prot_wr = wr && unlocked;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            cmp_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            if (prot_wr && addr == AW'(OFS_CFG))
                cfg_q <= unpack_cfg(data);
            if (prot_wr && addr == AW'(OFS_CMP))
                cmp_q <= data[CW-1:0];
            if (match)
                pend_q <= 1'b1;
            else if (prot_wr && addr == AW'(OFS_CFG))
                pend_q <= data[BIT_PEND];
        end
    end

    assign cfg_o      = cfg_q;
    assign cmp_o      = cmp_q;
    assign pend_o     = pend_q;
    assign feed_clr_o = prot_wr && addr == AW'(OFS_FEED) && data == DW'(FEED_WORD);

    AST_LOCKED_HELD: assert property (@(posedge clk) disable iff (rst)
        (wr && !unlocked) |=> ($stable(cfg_q) && $stable(cmp_q)))
        else $error("locked write changed a register"); // R4

    AST_MATCH_PEND: assert property (@(posedge clk) disable iff (rst)
        match |=> pend_q)
        else $error("match did not set pending"); // R7

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !(prot_wr && addr == AW'(OFS_CFG))) |=> pend_q)
        else $error("pending dropped on its own"); // R10
endmodule

// File: rtl/kwd_core.sv
module kwd_core
    import kwd_pkg::*;
#(
    parameter int unsigned NW = CNT_W,
    parameter int unsigned CW = CMP_W
) (
    input  logic          clk,
    input  logic          rst,
    input  cfg_t          cfg,
    input  logic [CW-1:0] cmp,
    input  logic          core_awake,
    input  logic          tick,
    input  logic          feed_clr,
    output logic [NW-1:0] count_o,
    output logic [CW-1:0] scaled_o,
    output logic          match_o
);
    logic [NW-1:0] cnt_q;
    logic          run;
    logic          armed;
    logic [CW-1:0] scaled;
    logic          match;

    assign run    = cfg.en_always || (cfg.en_awake && core_awake);
    assign armed  = cfg.en_always || cfg.en_awake;
    assign scaled = CW'(scale_count(CNT_W'(cnt_q), cfg.scale));
    assign match  = armed && (scaled >= cmp);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (feed_clr)
            cnt_q <= '0;
        else if (cfg.zero_cmp && match)
            cnt_q <= '0;
        else if (run && tick)
            cnt_q <= cnt_q + NW'(1);
    end

    assign count_o  = cnt_q;
    assign scaled_o = scaled;
    assign match_o  = match;

    AST_FEED_ZERO: assert property (@(posedge clk) disable iff (rst)
        feed_clr |=> (cnt_q == '0))
        else $error("feed did not clear counter"); // R5

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!tick && !feed_clr && !match) |=> $stable(cnt_q))
        else $error("counter moved without tick"); // R2

    AST_ZERO_AFTER_MATCH: assert property (@(posedge clk) disable iff (rst)
        (cfg.zero_cmp && match) |=> (cnt_q == '0))
        else $error("counter not zeroed after match"); // R8
endmodule

// File: rtl/keylock_wdog.sv
module keylock_wdog
    import kwd_pkg::*;
#(
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned DW = DATA_W,
    parameter int unsigned NW = CNT_W,
    parameter int unsigned CW = CMP_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          tick_i,
    input  logic          core_awake_i,
    output logic          irq_o,
    output logic          rst_req_o
);
    logic          unlocked;
    logic          match;
    logic          pend;
    logic          feed_clr;
    cfg_t          cfg;
    logic [CW-1:0] cmp;
    logic [NW-1:0] count;
    logic [CW-1:0] scaled;

    kwd_lock #(.AW(AW), .DW(DW)) lock_i (
        .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .data(bus_wdata),
        .unlocked_o(unlocked)
    );

    kwd_cfgregs #(.AW(AW), .DW(DW), .CW(CW)) regs_i (
        .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .data(bus_wdata),
        .unlocked(unlocked), .match(match),
        .cfg_o(cfg), .cmp_o(cmp), .pend_o(pend), .feed_clr_o(feed_clr)
    );

    kwd_core #(.NW(NW), .CW(CW)) core_i (
        .clk(clk), .rst(rst), .cfg(cfg), .cmp(cmp), .core_awake(core_awake_i),
        .tick(tick_i), .feed_clr(feed_clr),
        .count_o(count), .scaled_o(scaled), .match_o(match)
    );

    always_comb begin
        unique case (bus_addr)
            AW'(OFS_CFG): bus_rdata = DW'(pack_cfg(cfg, pend));
            AW'(OFS_RAW): bus_rdata = DW'(count);
            AW'(OFS_SCL): bus_rdata = DW'(scaled);
            AW'(OFS_KEY): bus_rdata = DW'(unlocked);
            AW'(OFS_CMP): bus_rdata = DW'(cmp);
            default:      bus_rdata = '0;
        endcase
    end

    assign irq_o     = pend;
    assign rst_req_o = pend && cfg.rst_en;

    AST_RST_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
        rst_req_o |-> irq_o)
        else $error("reset request without pending"); // R9
endmodule

// File: tb/keylock_wdog_tb_top.sv
`timescale 1ns/1ps
module keylock_wdog_tb_top;
    localparam logic [5:0]  A_CFG = 6'h00, A_RAW = 6'h08, A_SCL = 6'h10;
    localparam logic [5:0]  A_FEED = 6'h18, A_KEY = 6'h1C, A_CMP = 6'h20;
    localparam logic [31:0] KEYV = 32'h0051_F15E, FOOD = 32'h0D09_F00D;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_i = 1'b0;
    logic        core_awake_i = 1'b0;
    logic        irq_o, rst_req_o;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    keylock_wdog dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_i(tick_i),
        .core_awake_i(core_awake_i), .irq_o(irq_o), .rst_req_o(rst_req_o)
    );

    function automatic logic [31:0] exp_scaled(int unsigned n, int unsigned s);
        return {16'h0, 16'((n >> s) & 32'hFFFF)};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic uwr(input logic [5:0] a, input logic [31:0] d);
        wr(A_KEY, KEYV);
        wr(a, d);
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic ticks(input int unsigned n);
        for (int unsigned i = 0; i < n; i++) begin
            @(negedge clk); tick_i = 1'b1;
            @(negedge clk); tick_i = 1'b0;
        end
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd4321));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(A_CFG, v); check("R1 cfg", v, 0);
        rd(A_CMP, v); check("R1 cmp", v, 0);
        rd(A_RAW, v); check("R1 raw", v, 0);
        rd(A_KEY, v); check("R1 key", v, 0);
        check("R1 outs", {30'b0, irq_o, rst_req_o}, 0);

        // R4 locked writes ignored
        wr(A_CFG, 32'h0000_1000); rd(A_CFG, v); check("R4 cfg locked", v, 0);
        wr(A_CMP, 32'h0000_1234); rd(A_CMP, v); check("R4 cmp locked", v, 0);

        // R3 one-shot unlock
        wr(A_KEY, KEYV); rd(A_KEY, v); check("R3 unlocked", v, 1);
        wr(A_RAW, 0);    rd(A_KEY, v); check("R3 relocked", v, 0);
        wr(A_CMP, 32'h0000_0055); rd(A_CMP, v); check("R3 write after relock ignored", v, 0);
        uwr(A_CMP, 32'h0000_FFFF); rd(A_CMP, v); check("R3 unlocked write", v, 32'hFFFF);

        // R2 counting modes
        ticks(3); rd(A_RAW, v); check("R2 disabled hold", v, 0);
        uwr(A_CFG, 32'h0000_1000);
        ticks(5); rd(A_RAW, v); check("R2 always", v, 5);
        uwr(A_CFG, 32'h0000_2000);
        core_awake_i = 1'b0;
        ticks(4); rd(A_RAW, v); check("R2 asleep hold", v, 5);
        core_awake_i = 1'b1;
        ticks(4); rd(A_RAW, v); check("R2 awake count", v, 9);

        // R5 feed
        uwr(A_FEED, 32'h1234_5678); rd(A_RAW, v); check("R5 bad feed", v, 9);
        rd(A_KEY, v); check("R5 bad feed relocks", v, 0);
        wr(A_FEED, FOOD); rd(A_RAW, v); check("R4 locked feed", v, 9);
        uwr(A_FEED, FOOD); rd(A_RAW, v); check("R5 feed clears", v, 0);

        // R6 random bursts under random scales
        for (int it = 0; it < 16; it++) begin
            int unsigned s, n;
            s = $urandom_range(0, 6);
            n = $urandom_range(1, 300);
            core_awake_i = $urandom_range(0, 1);
            uwr(A_CFG, 0);
            uwr(A_FEED, FOOD);
            uwr(A_CFG, 32'h0000_1000 | s);
            ticks(n);
            rd(A_RAW, v); check("R6 raw", v, n);
            rd(A_SCL, v); check("R6 scaled", v, exp_scaled(n, s));
        end

        // R7 compare match and pending
        uwr(A_CFG, 0);
        uwr(A_CMP, 3);
        uwr(A_FEED, FOOD);
        uwr(A_CFG, 32'h0000_1000);
        ticks(2); #1; check("R7 below compare", {31'b0, irq_o}, 0);
        ticks(1); #1; check("R7 not yet pending", {31'b0, irq_o}, 0);
        @(negedge clk); #1; check("R7 pending", {31'b0, irq_o}, 1);
        rd(A_CFG, v); check("R7 cfg bit28", v, 32'h1000_1000);
        check("R9 reset gated", {31'b0, rst_req_o}, 0);
        uwr(A_CFG, 32'h0000_1100); #1;
        check("R9 reset req", {31'b0, rst_req_o}, 1);

        // R10 clear loses to a live match, then succeeds
        uwr(A_CFG, 32'h0000_0100); #1;
        check("R10 match wins", {31'b0, irq_o}, 1);
        uwr(A_CFG, 32'h0000_0100); #1;
        check("R10 cleared", {31'b0, irq_o}, 0);
        check("R9 reset drops", {31'b0, rst_req_o}, 0);
        wr(A_CFG, 32'h1000_0000); #1;
        check("R4 locked pend write", {31'b0, irq_o}, 0);

        // R8 zero on compare
        uwr(A_FEED, FOOD);
        uwr(A_CFG, 32'h0000_1200);
        ticks(3); rd(A_RAW, v); check("R8 at compare", v, 3);
        @(negedge clk); rd(A_RAW, v); check("R8 zeroed", v, 0);
        #1; check("R8 pending", {31'b0, irq_o}, 1);
        @(negedge clk); #1; check("R10 sticky", {31'b0, irq_o}, 1);
        uwr(A_CFG, 32'h0000_1200); #1;
        check("R10 clear", {31'b0, irq_o}, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule